// File: doc/BRIEF.md
# Extended Feature Control Register

This block holds one 64-bit privileged control register. The register turns on optional processor features: system-call extensions, long-mode enable, no-execute paging protection, the virtualization extensions and a fast save/restore path. It also keeps a long-mode-active status bit that only hardware can change. Software reaches the register through a single-cycle access port. An access counts only when its address matches the register's fixed address and the caller runs at privilege level 0. A read returns its data on the cycle after the request.

Two outputs are qualified versions of stored bits. The fast save/restore enable takes effect only while the core runs in 64-bit mode at privilege level 0. The undefined-opcode qualifier for virtualization instructions is high whenever the virtualization enable is clear. Illegal accesses produce a one-cycle fault strobe and leave the register untouched. Illegal accesses are: a write that sets a must-be-zero bit, a write that sets the virtualization enable while virtualization is globally disabled, and any access from a non-zero privilege level.

Top module: `featctl_reg`

## Requirements
- R1: After a synchronous reset, every feature enable, `lm_active`, `fault` and `rd_data` are 0, and `virt_ud` is 1.
- R2: A write at privilege level 0 to address `REG_ADDR` (default 32'hC000_0080) with no fault condition loads data bit 0 (system calls), bit 8 (long-mode enable), bit 11 (no-execute), bit 12 (virtualization) and bit 14 (fast save/restore). The enables show the new values after the next clock edge. An access to any other address changes nothing and raises no fault.
- R3: A read at privilege level 0 returns the register image on `rd_data` one cycle later, with `lm_active` at bit 10. Bits 1 to 7 always read as 0. Writes to bits 1 to 7 or bit 10 are dropped without a fault. `rd_data` is 0 in every cycle that does not follow such a read.
- R4: A write with any of bits 9, 13 or 15 to 63 set raises `fault` for one cycle, one cycle after the request, and leaves every stored bit unchanged.
- R5: `lm_active` is set at a clock edge where `paging_on` is high, was low at the previous edge, and the stored long-mode enable is 1. The stored value is the one held before any write in the same cycle. `lm_active` clears at any edge where `paging_on` is low.
- R6: `virt_ud` is the inverse of the stored virtualization enable.
- R7: While `virt_block` is high, a write with bit 12 set faults and changes nothing. A write with bit 12 clear is accepted.
- R8: `en_fastsave` is registered. It equals the stored bit 14 AND `wide_mode` AND (`priv_lvl` == 0), all sampled at the previous edge.
- R9: An access to the register address with `priv_lvl` other than 0 raises `fault`, returns 0 on `rd_data` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register address of the access |
| acc_wdata | input | 64 | Write data |
| priv_lvl | input | PL_W | Current privilege level, 0 = most privileged |
| paging_on | input | 1 | Paging enable state |
| wide_mode | input | 1 | Core is in 64-bit mode |
| virt_block | input | 1 | Global virtualization disable |
| rd_data | output | 64 | Read data, valid the cycle after a read |
| fault | output | 1 | One-cycle illegal-access strobe |
| en_syscall | output | 1 | System-call extensions enable |
| en_longmode | output | 1 | Long-mode enable |
| lm_active | output | 1 | Long mode active status |
| en_noexec | output | 1 | No-execute protection enable |
| en_virt | output | 1 | Virtualization extensions enable |
| en_fastsave | output | 1 | Effective fast save/restore enable |
| virt_ud | output | 1 | Flag virtualization instructions as undefined |

## Verification
A write and a paging-on rising edge can arrive in the same cycle. The bench provokes this by raising `paging_on` with a write that sets the long-mode enable from 0, and again with a write that clears it from 1. The bench model then checks that `lm_active` follows the enable value stored before the write. Fault-raising writes and the qualified fast save/restore output are swept over every single-bit write pattern and over every combination of mode and privilege level.

// File: rtl/featctl_pkg.sv
`timescale 1ns/1ps
package featctl_pkg;
  localparam int XLEN   = 64;
  localparam int B_SYSC = 0;
  localparam int B_LME  = 8;
  localparam int B_LMA  = 10;
  localparam int B_NXE  = 11;
  localparam int B_VIRT = 12;
  localparam int B_FSR  = 14;

  typedef struct packed {
    logic sysc;
    logic lme;
    logic nxe;
    logic virt;
    logic fsr;
  } feat_t;

  // bits that fault when written as one: 9, 13 and 15 upward
  function automatic logic [XLEN-1:0] mbz_mask();
    logic [XLEN-1:0] m;
    m = {XLEN{1'b1}} << 15;
    m[9]  = 1'b1;
    m[13] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] image(feat_t f, logic lma);
    logic [XLEN-1:0] v;
    v = '0;
    v[B_SYSC] = f.sysc;
    v[B_LME]  = f.lme;
    v[B_LMA]  = lma;
    v[B_NXE]  = f.nxe;
    v[B_VIRT] = f.virt;
    v[B_FSR]  = f.fsr;
    return v;
  endfunction
endpackage

// File: rtl/featctl_access.sv
`timescale 1ns/1ps
module featctl_access
  import featctl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PL_W = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = 32'hC000_0080
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [XLEN-1:0]   acc_wdata,
  input  logic [PL_W-1:0]   priv_lvl,
  input  logic              virt_block,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              bad
);
  localparam logic [XLEN-1:0] MBZ = mbz_mask();

  logic hit, priv, wr_bad;

  always_comb begin
    hit    = acc_valid && (acc_addr == REG_ADDR);
    priv   = (priv_lvl == '0);
    wr_bad = ((acc_wdata & MBZ) != '0) || (virt_block && acc_wdata[B_VIRT]);
    bad    = hit && (!priv || (acc_write && wr_bad));
    wr_ok  = hit && priv && acc_write && !wr_bad;
    rd_ok  = hit && priv && !acc_write;
  end
endmodule

// File: rtl/featctl_store.sv
`timescale 1ns/1ps
module featctl_store
  import featctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_ok,
  input  logic [XLEN-1:0] wdata,
  input  logic            paging_on,
  output feat_t           feat,
  output logic            lma
);
  logic pg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      feat <= '0;
      lma  <= 1'b0;
      pg_q <= 1'b0;
    end else begin
      pg_q <= paging_on;
      if (wr_ok) begin
        feat.sysc <= wdata[B_SYSC];
        feat.lme  <= wdata[B_LME];
        feat.nxe  <= wdata[B_NXE];
        feat.virt <= wdata[B_VIRT];
        feat.fsr  <= wdata[B_FSR];
      end
      if (!paging_on)
        lma <= 1'b0;
      else if (!pg_q && feat.lme)
        lma <= 1'b1;
    end
  end

  assert_lma_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(lma) |-> ($past(feat.lme) && $past(paging_on)));

  assert_lma_drop_R5: assert property (@(posedge clk) disable iff (rst)
    !paging_on |=> !lma);
endmodule

// File: rtl/featctl_qual.sv
`timescale 1ns/1ps
module featctl_qual
  import featctl_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  feat_t           feat,
  input  logic            lma,
  input  logic            rd_ok,
  input  logic            bad,
  input  logic            wide_mode,
  input  logic [PL_W-1:0] priv_lvl,
  output logic [XLEN-1:0] rd_data,
  output logic            fault,
  output logic            en_fastsave
);
  localparam logic [XLEN-1:0] UNUSED = ~image('1, 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      fault       <= 1'b0;
      en_fastsave <= 1'b0;
    end else begin
      fault       <= bad;
      rd_data     <= rd_ok ? image(feat, lma) : '0;
      en_fastsave <= feat.fsr && wide_mode && (priv_lvl == '0);
    end
  end

  assert_rd_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_data != '0) |-> ($past(rd_ok) && $past(priv_lvl == '0)));

  assert_rd_unused_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_data & UNUSED) == '0);

  assert_fs_gate_R8: assert property (@(posedge clk) disable iff (rst)
    en_fastsave |-> ($past(wide_mode) && $past(priv_lvl == '0) && $past(feat.fsr)));
endmodule

// File: rtl/featctl_reg.sv
`timescale 1ns/1ps
module featctl_reg
  import featctl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PL_W = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = 32'hC000_0080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [63:0]       acc_wdata,
  input  logic [PL_W-1:0]   priv_lvl,
  input  logic              paging_on,
  input  logic              wide_mode,
  input  logic              virt_block,
  output logic [63:0]       rd_data,
  output logic              fault,
  output logic              en_syscall,
  output logic              en_longmode,
  output logic              lm_active,
  output logic              en_noexec,
  output logic              en_virt,
  output logic              en_fastsave,
  output logic              virt_ud
);
  logic  wr_ok, rd_ok, bad, lma;
  feat_t feat;

  featctl_access #(.ADDR_W(ADDR_W), .PL_W(PL_W), .REG_ADDR(REG_ADDR)) u_acc (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .priv_lvl(priv_lvl), .virt_block(virt_block),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .bad(bad)
  );

  featctl_store u_store (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wdata(acc_wdata),
    .paging_on(paging_on), .feat(feat), .lma(lma)
  );

  featctl_qual #(.PL_W(PL_W)) u_qual (
    .clk(clk), .rst(rst), .feat(feat), .lma(lma), .rd_ok(rd_ok), .bad(bad),
    .wide_mode(wide_mode), .priv_lvl(priv_lvl), .rd_data(rd_data),
    .fault(fault), .en_fastsave(en_fastsave)
  );

  assign en_syscall  = feat.sysc;
  assign en_longmode = feat.lme;
  assign en_noexec   = feat.nxe;
  assign en_virt     = feat.virt;
  assign lm_active   = lma;
  assign virt_ud     = !feat.virt;

  // R4, R7, R9: the cycle a fault is shown, no stored bit moved at that edge
  assert_fault_hold_R4: assert property (@(posedge clk) disable iff (rst)
    fault |-> $stable(feat));
endmodule

// File: tb/tb_featctl_reg.sv
`timescale 1ns/1ps
module tb_featctl_reg;
  localparam logic [31:0] ADDR = 32'hC000_0080;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [63:0] acc_wdata = '0;
  logic [1:0]  priv_lvl = '0;
  logic        paging_on = 1'b0, wide_mode = 1'b0, virt_block = 1'b0;
  logic [63:0] rd_data;
  logic        fault, en_syscall, en_longmode, lm_active, en_noexec;
  logic        en_virt, en_fastsave, virt_ud;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model
  logic [63:0] m_img = '0;
  logic        m_lma = 1'b0, m_pg = 1'b0;

  featctl_reg dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .priv_lvl(priv_lvl),
    .paging_on(paging_on), .wide_mode(wide_mode), .virt_block(virt_block),
    .rd_data(rd_data), .fault(fault), .en_syscall(en_syscall),
    .en_longmode(en_longmode), .lm_active(lm_active), .en_noexec(en_noexec),
    .en_virt(en_virt), .en_fastsave(en_fastsave), .virt_ud(virt_ud)
  );

  always #5 clk = ~clk;

  function automatic logic [63:0] mbzm();
    return (~64'h0 << 15) | (64'h1 << 9) | (64'h1 << 13);
  endfunction

  function automatic logic [63:0] swm();
    return (64'h1 << 0) | (64'h1 << 8) | (64'h1 << 11) | (64'h1 << 12) | (64'h1 << 14);
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [63:0] e_rd;
  logic        e_fault, e_fs;

  // one cycle: drive at negedge, model at posedge, check just after
  task automatic step(logic v, logic w, logic [31:0] a, logic [63:0] d,
                      logic [1:0] pl, string tag);
    logic hit, bd;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d; priv_lvl = pl;
    @(posedge clk);
    hit = v && (a == ADDR);
    bd  = hit && ((pl != 2'd0) || (w && (((d & mbzm()) != 0) || (virt_block && d[12]))));
    e_fault = bd;
    e_rd = (hit && !w && pl == 2'd0) ? (m_img | ({63'd0, m_lma} << 10)) : 64'd0;
    e_fs = m_img[14] && wide_mode && (pl == 2'd0);
    if (!paging_on) m_lma = 1'b0;
    else if (!m_pg && m_img[8]) m_lma = 1'b1;
    m_pg = paging_on;
    if (hit && w && !bd) m_img = d & swm();
    #1;
    chk(tag, "fault", {63'd0, fault}, {63'd0, e_fault});
    chk(tag, "rd_data", rd_data, e_rd);
    chk(tag, "enables", {58'd0, en_syscall, en_longmode, en_noexec, en_virt, lm_active, virt_ud},
        {58'd0, m_img[0], m_img[8], m_img[11], m_img[12], m_lma, !m_img[12]});
    chk(tag, "en_fastsave", {63'd0, en_fastsave}, {63'd0, e_fs});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "rd_data", rd_data, 64'd0);
    chk("R1", "outs", {58'd0, fault, en_syscall, en_longmode, en_noexec, en_virt, lm_active},
        64'd0);
    chk("R1", "virt_ud", {63'd0, virt_ud}, 64'd1);
    chk("R1", "en_fastsave", {63'd0, en_fastsave}, 64'd0);

    // R2 load all implemented bits, read back, other address ignored
    step(1, 1, ADDR, swm(), 2'd0, "R2");
    step(1, 0, ADDR, 0, 2'd0, "R2");
    step(1, 1, ADDR + 32'd1, 64'd0, 2'd0, "R2");
    step(1, 0, ADDR, 0, 2'd0, "R2");
    step(1, 1, ADDR, 64'h4801, 2'd0, "R6");
    step(1, 0, ADDR, 0, 2'd0, "R3");

    // R3/R4 single-bit sweep: fault on must-be-zero, dropped on read-as-zero
    for (int b = 0; b < 64; b++) begin
      string tg;
      logic [63:0] one;
      one = 64'h1 << b;
      tg = ((one & mbzm()) != 0) ? "R4" : "R3";
      step(1, 1, ADDR, one | 64'h0100, 2'd0, tg);
      step(1, 0, ADDR, 0, 2'd0, tg);
    end
    step(1, 1, ADDR, 64'h00FE | 64'h0400, 2'd0, "R3");
    step(1, 0, ADDR, 0, 2'd0, "R3");

    // R7 global virtualization disable
    virt_block = 1'b1;
    step(1, 1, ADDR, 64'h1000, 2'd0, "R7");
    step(1, 1, ADDR, 64'h0801, 2'd0, "R7");
    step(1, 0, ADDR, 0, 2'd0, "R7");
    virt_block = 1'b0;
    step(1, 1, ADDR, 64'h1000, 2'd0, "R6");
    step(1, 0, ADDR, 0, 2'd0, "R6");

    // R9 unprivileged reads and writes
    for (int p = 1; p < 4; p++) begin
      step(1, 1, ADDR, 64'h0001, 2'(p), "R9");
      step(1, 0, ADDR, 0, 2'(p), "R9");
    end

    // R8 sweep of stored bit, mode and privilege level
    for (int f = 0; f < 2; f++)
      for (int wm = 0; wm < 2; wm++)
        for (int p = 0; p < 4; p++) begin
          step(1, 1, ADDR, (f != 0) ? 64'h4000 : 64'h0, 2'd0, "R8");
          wide_mode = wm[0];
          step(0, 0, ADDR, 0, 2'(p), "R8");
          step(0, 0, ADDR, 0, 2'(p), "R8");
          wide_mode = 1'b0;
        end

    // R5 long-mode activation, including write and paging edge together
    step(1, 1, ADDR, 64'h0000, 2'd0, "R5");
    paging_on = 1'b1;
    step(1, 1, ADDR, 64'h0100, 2'd0, "R5");  // old enable 0: stays inactive
    step(1, 0, ADDR, 0, 2'd0, "R5");
    paging_on = 1'b0;
    step(0, 0, ADDR, 0, 2'd0, "R5");
    paging_on = 1'b1;
    step(1, 1, ADDR, 64'h0000, 2'd0, "R5");  // old enable 1: becomes active
    step(1, 0, ADDR, 0, 2'd0, "R5");
    step(1, 1, ADDR, 64'h0500, 2'd0, "R5");  // bit 10 write dropped
    step(1, 0, ADDR, 0, 2'd0, "R5");
    paging_on = 1'b0;
    step(1, 0, ADDR, 0, 2'd0, "R5");
    step(1, 0, ADDR, 0, 2'd0, "R5");
    paging_on = 1'b1;
    step(0, 0, ADDR, 0, 2'd0, "R5");
    step(1, 0, ADDR, 0, 2'd0, "R5");
    paging_on = 1'b0;
    step(0, 0, ADDR, 0, 2'd0, "R5");

    finish_run();
  end
endmodule